// File: doc/BRIEF.md
# I2C Expander Command Pointer Decoder

This block is the address and command front end of a GPIO expander that sits on an I2C bus as a slave. A separate bit-level engine turns SCL/SDA activity into single-cycle events: start, stop, a received 7-bit address with its R/W bit, and a received data byte. For each event the block decides in the same cycle whether the byte is to be acknowledged. It recognises the device's own address and three broadcast addresses. It also keeps an 8-bit command register. The low six bits of that register point at the register being accessed. The top bit turns on auto-increment of the pointer.

In a write transfer, the first byte after the address is the command. The block checks it against the legal register map and loads it only if it is legal. The bytes that follow are data. For each one the block raises a write strobe at the current pointer and then advances the pointer, unless the target is read-only. In a read transfer, each byte handed out advances the pointer in the same way. The register map has five five-bank groups: input, output, polarity, config and mask, with bases 00h, 08h, 10h, 18h and 20h. It also has three single registers at 28h, 29h and 2Ah. The register contents are outside this block.

Top module: `xpnd_cmd_front`

## Requirements
- R1: After reset the command register holds 80h, so reg_ptr_o is 0 and auto-increment is on. ack_o and reg_we_o are 0, and match_o is 0 (none).
- R2: Right after a start, an address equal to own_addr_i is acknowledged for either R/W value. From the next cycle match_o reads 1 (own).
- R3: The broadcast addresses take precedence over own_addr_i. 0001100 is acknowledged only with R/W=1 (match_o=2). 1101110 is acknowledged only with R/W=0 (match_o=3). 1111100 is acknowledged with either R/W value (match_o=4).
- R4: An address is weighed only as the first event after a start. An unrecognised address is refused with match_o=0. An address event at any other time is refused and has no effect.
- R5: The first byte after an acknowledged write address (own or all-call) is the command. It is acknowledged and loaded only if its low 7 bits lie in 00h–04h, 08h–0Ch, 10h–14h, 18h–1Ch, 20h–24h or 28h–2Ah. The pointer is then its bits 5:0 and auto-increment is its bit 7.
- R6: A refused command leaves the command register unchanged, and every later byte of that transfer is refused.
- R7: A write data byte while the pointer is in 00h–04h (input registers) is refused without a write strobe. Every later byte of that transfer is refused.
- R8: A write data byte aimed at any other register is acknowledged, and reg_we_o is high in the same cycle, with reg_ptr_o naming the target.
- R9: With auto-increment on, the pointer advances after each written or read data byte. Within a five-bank group it wraps from offset 4 back to offset 0. 28h, 29h and 2Ah do not advance.
- R10: With auto-increment off, data bytes leave the pointer unchanged.
- R11: A stop or a repeated start ends the transfer, clears match_o to 0 and keeps the pointer. A following read starts at the stored pointer. Read bytes are never acknowledged by this block.
- R12: Data bytes in an alert-response or device-ID transfer are refused. They raise no write strobe and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated start seen |
| stop_i | input | 1 | Stop seen |
| addr_valid_i | input | 1 | Address byte received |
| addr_i | input | 7 | Received 7-bit address |
| rw_i | input | 1 | R/W bit of the address byte (1 = read) |
| byte_valid_i | input | 1 | Data byte received (write) or handed out (read) |
| byte_i | input | 8 | Received data byte |
| own_addr_i | input | 7 | Device's own slave address |
| ack_o | output | 1 | Acknowledge decision for the event in this cycle |
| reg_ptr_o | output | 6 | Current register pointer |
| reg_we_o | output | 1 | Write strobe for byte_i into the register at reg_ptr_o |
| match_o | output | 3 | Address class of the current transfer: 0 none, 1 own, 2 alert, 3 all-call, 4 device ID |

## Verification
Several rules are checked by assertions on every cycle:
- the command register only ever holds a legal code;
- a refused command freezes the pointer;
- a write strobe never occurs without an acknowledge, or while the pointer is on an input register;
- the alert address with a write bit is never acknowledged;
- an address outside the post-start slot is never acknowledged;
- the bank wrap occurs as specified;
- a stop clears the match type.

Other behaviour depends on a chain of events and is shown only by the bench scenarios. This includes a repeated start followed by a read from the kept pointer, single registers holding still under auto-increment, and the refusal of every byte after a rejected command or a write to an input register.

// File: rtl/xpnd_pkg.sv
package xpnd_pkg;

    localparam int ADDR_W      = 7;
    localparam int CMD_W       = 8;
    localparam int PTR_W       = 6;
    localparam int N_BANKS     = 5;
    localparam int N_GROUPS    = 5;
    localparam int BANK_STRIDE = 8;
    localparam int BSEL_W      = $clog2(BANK_STRIDE);
    localparam int N_SINGLE    = 3;
    localparam int SINGLE_BASE = N_GROUPS * BANK_STRIDE;
    localparam int MATCH_W     = 3;

    localparam logic [ADDR_W-1:0] ALERT_ADDR_DEF   = 7'b0001100;
    localparam logic [ADDR_W-1:0] ALLCALL_ADDR_DEF = 7'b1101110;
    localparam logic [ADDR_W-1:0] DEVID_ADDR_DEF   = 7'b1111100;

    typedef enum logic [MATCH_W-1:0] {
        M_NONE    = 3'd0,
        M_OWN     = 3'd1,
        M_ALERT   = 3'd2,
        M_ALLCALL = 3'd3,
        M_DEVID   = 3'd4
    } match_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_WDATA,
        S_RDATA,
        S_SPEC
    } seq_e;

    // A code is legal when it falls inside a bank group or on a single register.
    function automatic logic code_legal(input logic [CMD_W-2:0] code);
        int   c;
        logic ok;
        c  = int'(code);
        ok = 1'b0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (c >= g * BANK_STRIDE && c < g * BANK_STRIDE + N_BANKS)
                ok = 1'b1;
        end
        if (c >= SINGLE_BASE && c < SINGLE_BASE + N_SINGLE)
            ok = 1'b1;
        return ok;
    endfunction

    // Next pointer under auto-increment: wrap inside a group, hold on singles.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (int'(p) >= SINGLE_BASE)
            return p;
        if (int'(p[BSEL_W-1:0]) == N_BANKS - 1)
            return {p[PTR_W-1:BSEL_W], {BSEL_W{1'b0}}};
        return p + PTR_W'(1);
    endfunction

    function automatic logic ptr_read_only(input logic [PTR_W-1:0] p);
        return int'(p) < N_BANKS;
    endfunction

endpackage

// File: rtl/xpnd_addr_match.sv
module xpnd_addr_match
    import xpnd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALERT_ADDR   = ALERT_ADDR_DEF,
    parameter logic [ADDR_W-1:0] ALLCALL_ADDR = ALLCALL_ADDR_DEF,
    parameter logic [ADDR_W-1:0] DEVID_ADDR   = DEVID_ADDR_DEF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rw_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output match_e            cls_o
);

    // Broadcast addresses are checked ahead of the device's own address.
    always_comb begin
        if (addr_i == ALERT_ADDR && rw_i)
            cls_o = M_ALERT;
        else if (addr_i == ALLCALL_ADDR && !rw_i)
            cls_o = M_ALLCALL;
        else if (addr_i == DEVID_ADDR)
            cls_o = M_DEVID;
        else if (addr_i == own_addr_i)
            cls_o = M_OWN;
        else
            cls_o = M_NONE;
    end

endmodule

// File: rtl/xpnd_cmd_reg.sv
module xpnd_cmd_reg
    import xpnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CMD_W-1:0] load_val_i,
    input  logic             adv_i,
    output logic [CMD_W-1:0] cmd_o
);

    localparam logic [CMD_W-1:0] CMD_RST = {1'b1, {(CMD_W-1){1'b0}}};
    localparam int               AI_BIT  = CMD_W - 1;

    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= CMD_RST;
        else if (load_i)
            cmd_q <= load_val_i;
        else if (adv_i && cmd_q[AI_BIT])
            cmd_q[PTR_W-1:0] <= ptr_next(cmd_q[PTR_W-1:0]);
    end

    assign cmd_o = cmd_q;

    // R5
    cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
        code_legal(cmd_q[CMD_W-2:0]));

    // R9
    bank_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && cmd_q[AI_BIT] && int'(cmd_q[PTR_W-1:0]) < SINGLE_BASE
         && int'(cmd_q[BSEL_W-1:0]) == N_BANKS - 1)
        |=> (cmd_q[BSEL_W-1:0] == '0));

    // R10
    no_ai_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && !cmd_q[AI_BIT]) |=> $stable(cmd_q));

endmodule

// File: rtl/xpnd_cmd_front.sv
module xpnd_cmd_front
    import xpnd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALERT_ADDR   = ALERT_ADDR_DEF,
    parameter logic [ADDR_W-1:0] ALLCALL_ADDR = ALLCALL_ADDR_DEF,
    parameter logic [ADDR_W-1:0] DEVID_ADDR   = DEVID_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              addr_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rw_i,
    input  logic              byte_valid_i,
    input  logic [CMD_W-1:0]  byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              ack_o,
    output logic [PTR_W-1:0]  reg_ptr_o,
    output logic              reg_we_o,
    output logic [MATCH_W-1:0] match_o
);

    seq_e             st_q, st_d;
    match_e           mt_q, mt_d;
    match_e           cls;
    logic             cmd_load, ptr_adv;
    logic [CMD_W-1:0] cmd;

    xpnd_addr_match #(
        .ALERT_ADDR  (ALERT_ADDR),
        .ALLCALL_ADDR(ALLCALL_ADDR),
        .DEVID_ADDR  (DEVID_ADDR)
    ) u_match (
        .addr_i    (addr_i),
        .rw_i      (rw_i),
        .own_addr_i(own_addr_i),
        .cls_o     (cls)
    );

    xpnd_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .load_i    (cmd_load),
        .load_val_i(byte_i),
        .adv_i     (ptr_adv),
        .cmd_o     (cmd)
    );

    assign reg_ptr_o = cmd[PTR_W-1:0];

    always_comb begin
        st_d     = st_q;
        mt_d     = mt_q;
        ack_o    = 1'b0;
        reg_we_o = 1'b0;
        cmd_load = 1'b0;
        ptr_adv  = 1'b0;
        if (stop_i) begin
            st_d = S_IDLE;
            mt_d = M_NONE;
        end else if (start_i) begin
            st_d = S_ADDR;
            mt_d = M_NONE;
        end else if (addr_valid_i) begin
            if (st_q == S_ADDR) begin
                if (cls == M_NONE) begin
                    st_d = S_IDLE;
                end else begin
                    ack_o = 1'b1;
                    mt_d  = cls;
                    case (cls)
                        M_OWN:     st_d = rw_i ? S_RDATA : S_CMD;
                        M_ALLCALL: st_d = S_CMD;
                        default:   st_d = S_SPEC;
                    endcase
                end
            end
        end else if (byte_valid_i) begin
            case (st_q)
                S_CMD: begin
                    if (code_legal(byte_i[CMD_W-2:0])) begin
                        ack_o    = 1'b1;
                        cmd_load = 1'b1;
                        st_d     = S_WDATA;
                    end else begin
                        st_d = S_IDLE;
                    end
                end
                S_WDATA: begin
                    if (ptr_read_only(reg_ptr_o)) begin
                        st_d = S_IDLE;
                    end else begin
                        ack_o    = 1'b1;
                        reg_we_o = 1'b1;
                        ptr_adv  = 1'b1;
                    end
                end
                S_RDATA: ptr_adv = 1'b1;
                S_ADDR:  st_d = S_IDLE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
            mt_q <= M_NONE;
        end else begin
            st_q <= st_d;
            mt_q <= mt_d;
        end
    end

    assign match_o = mt_q;

    // R3
    alert_write_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_i && !start_i && !stop_i && !rw_i && addr_i == ALERT_ADDR
         && own_addr_i != ALERT_ADDR) |-> !ack_o);

    // R4
    addr_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_i && !start_i && !stop_i && st_q != S_ADDR) |-> !ack_o);

    // R6
    bad_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_i && !addr_valid_i && !start_i && !stop_i && st_q == S_CMD && !ack_o)
        |=> $stable(reg_ptr_o));

    // R7
    we_target_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> (ack_o && byte_valid_i && int'(reg_ptr_o) >= N_BANKS));

    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (match_o == 3'd0));

endmodule

// File: tb/sim_xpnd_cmd_front.sv
module sim_xpnd_cmd_front;

    localparam int EV_START = 0, EV_STOP = 1, EV_ADDR = 2, EV_BYTE = 3;
    localparam int B_IDLE = 0, B_ADDR = 1, B_CMD = 2, B_WDATA = 3, B_RDATA = 4, B_SPEC = 5;
    localparam logic [6:0] OWN = 7'h20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 0, stop_i = 0, addr_valid_i = 0, rw_i = 0, byte_valid_i = 0;
    logic [6:0] addr_i = '0;
    logic [7:0] byte_i = '0;
    logic [6:0] own_addr_i = OWN;
    logic       ack_o, reg_we_o;
    logic [5:0] reg_ptr_o;
    logic [2:0] match_o;

    int checks = 0;
    int errors = 0;

    int         m_st = B_IDLE;
    logic [7:0] m_cmd = 8'h80;
    logic [2:0] m_match = 3'd0;

    always #10 clk = ~clk;

    xpnd_cmd_front u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .addr_valid_i(addr_valid_i), .addr_i(addr_i), .rw_i(rw_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .own_addr_i(own_addr_i),
        .ack_o(ack_o), .reg_ptr_o(reg_ptr_o), .reg_we_o(reg_we_o), .match_o(match_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit legal(input logic [6:0] c);
        int v = int'(c);
        if (v < 40) return (v % 8) < 5;
        return v <= 42;
    endfunction

    function automatic logic [5:0] nxt(input logic [5:0] p);
        if (p >= 6'h28) return p;
        if (p[2:0] == 3'd4) return {p[5:3], 3'd0};
        return p + 6'd1;
    endfunction

    function automatic logic [2:0] classify(input logic [6:0] a, input logic r);
        if (a == 7'b0001100 && r) return 3'd2;
        if (a == 7'b1101110 && !r) return 3'd3;
        if (a == 7'b1111100) return 3'd4;
        if (a == own_addr_i) return 3'd1;
        return 3'd0;
    endfunction

    task automatic ev(input int kind, input logic [6:0] a, input logic r,
                      input logic [7:0] b, input string tag);
        bit         e_ack, e_we;
        logic [2:0] c;
        @(negedge clk);
        start_i      = (kind == EV_START);
        stop_i       = (kind == EV_STOP);
        addr_valid_i = (kind == EV_ADDR);
        byte_valid_i = (kind == EV_BYTE);
        addr_i = a; rw_i = r; byte_i = b;
        #5;
        e_ack = 0; e_we = 0;
        case (kind)
            EV_START: begin m_st = B_ADDR; m_match = 3'd0; end
            EV_STOP:  begin m_st = B_IDLE; m_match = 3'd0; end
            EV_ADDR: if (m_st == B_ADDR) begin
                c = classify(a, r);
                if (c == 3'd0) m_st = B_IDLE;
                else begin
                    e_ack = 1; m_match = c;
                    if (c == 3'd1) m_st = r ? B_RDATA : B_CMD;
                    else if (c == 3'd3) m_st = B_CMD;
                    else m_st = B_SPEC;
                end
            end
            default: case (m_st)
                B_CMD: if (legal(b[6:0])) begin e_ack = 1; m_st = B_WDATA; end
                       else m_st = B_IDLE;
                B_WDATA: if (m_cmd[5:0] < 6'd5) m_st = B_IDLE;
                         else begin e_ack = 1; e_we = 1; end
                B_ADDR: m_st = B_IDLE;
                default: ;
            endcase
        endcase
        chk(ack_o == e_ack, tag, "ack_o", int'(ack_o), int'(e_ack));
        chk(reg_we_o == e_we, tag, "reg_we_o", int'(reg_we_o), int'(e_we));
        chk(reg_ptr_o == m_cmd[5:0], tag, "reg_ptr_o", int'(reg_ptr_o), int'(m_cmd[5:0]));
        @(posedge clk);
        #1;
        if (kind == EV_BYTE && e_ack && !e_we) m_cmd = b;
        else if (kind == EV_BYTE && m_cmd[7] &&
                 (e_we || (m_st == B_RDATA))) m_cmd[5:0] = nxt(m_cmd[5:0]);
        start_i = 0; stop_i = 0; addr_valid_i = 0; byte_valid_i = 0;
        chk(match_o == m_match, tag, "match_o", int'(match_o), int'(m_match));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1d2c3b4a);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(reg_ptr_o == 6'd0, "R1", "reg_ptr_o", int'(reg_ptr_o), 0);
        chk(ack_o == 1'b0 && reg_we_o == 1'b0, "R1", "ack/we", int'({ack_o, reg_we_o}), 0);
        chk(match_o == 3'd0, "R1", "match_o", int'(match_o), 0);

        // R1 AI set after reset: read advances pointer
        ev(EV_START, 0, 0, 0, "R1");
        ev(EV_ADDR, OWN, 1, 0, "R2");
        ev(EV_BYTE, 0, 0, 0, "R1");
        chk(reg_ptr_o == 6'd1, "R1", "ai pointer", int'(reg_ptr_o), 1);
        ev(EV_STOP, 0, 0, 0, "R11");

        // R2 / R5 / R8 / R10 command without AI
        ev(EV_START, 0, 0, 0, "R2");
        ev(EV_ADDR, OWN, 0, 0, "R2");
        ev(EV_BYTE, 0, 0, 8'h0A, "R5");
        ev(EV_BYTE, 0, 0, 8'h5A, "R8");
        ev(EV_BYTE, 0, 0, 8'h33, "R10");
        chk(reg_ptr_o == 6'h0A, "R10", "pointer fixed", int'(reg_ptr_o), 'h0A);

        // R11 repeated start then read from kept pointer
        ev(EV_START, 0, 0, 0, "R11");
        ev(EV_ADDR, OWN, 1, 0, "R11");
        ev(EV_BYTE, 0, 0, 8'hFF, "R11");
        ev(EV_STOP, 0, 0, 0, "R11");

        // R6 illegal command and following byte
        ev(EV_START, 0, 0, 0, "R6");
        ev(EV_ADDR, OWN, 0, 0, "R6");
        ev(EV_BYTE, 0, 0, 8'h33, "R6");
        ev(EV_BYTE, 0, 0, 8'h08, "R6");
        ev(EV_BYTE, 0, 0, 8'h45, "R6");

        // R7 write to input register
        ev(EV_START, 0, 0, 0, "R7");
        ev(EV_ADDR, OWN, 0, 0, "R7");
        ev(EV_BYTE, 0, 0, 8'h84, "R5");
        ev(EV_BYTE, 0, 0, 8'h11, "R7");
        ev(EV_BYTE, 0, 0, 8'h22, "R7");

        // R9 bank wrap and single register hold
        ev(EV_START, 0, 0, 0, "R9");
        ev(EV_ADDR, OWN, 0, 0, "R9");
        ev(EV_BYTE, 0, 0, 8'h9C, "R9");
        ev(EV_BYTE, 0, 0, 8'h01, "R9");
        chk(reg_ptr_o == 6'h18, "R9", "wrap", int'(reg_ptr_o), 'h18);
        ev(EV_START, 0, 0, 0, "R9");
        ev(EV_ADDR, OWN, 0, 0, "R9");
        ev(EV_BYTE, 0, 0, 8'hA9, "R9");
        ev(EV_BYTE, 0, 0, 8'h01, "R9");
        ev(EV_BYTE, 0, 0, 8'h02, "R9");
        chk(reg_ptr_o == 6'h29, "R9", "single hold", int'(reg_ptr_o), 'h29);

        // R3 broadcast addresses, R12 special data bytes
        ev(EV_START, 0, 0, 0, "R3");
        ev(EV_ADDR, 7'b0001100, 0, 0, "R3");
        ev(EV_START, 0, 0, 0, "R3");
        ev(EV_ADDR, 7'b0001100, 1, 0, "R3");
        ev(EV_BYTE, 0, 0, 8'h10, "R12");
        ev(EV_START, 0, 0, 0, "R3");
        ev(EV_ADDR, 7'b1101110, 1, 0, "R3");
        ev(EV_START, 0, 0, 0, "R3");
        ev(EV_ADDR, 7'b1101110, 0, 0, "R3");
        ev(EV_BYTE, 0, 0, 8'h12, "R5");
        ev(EV_START, 0, 0, 0, "R3");
        ev(EV_ADDR, 7'b1111100, 0, 0, "R3");
        ev(EV_BYTE, 0, 0, 8'h08, "R12");
        ev(EV_STOP, 0, 0, 0, "R11");

        // R4 address without start, and unknown address
        ev(EV_ADDR, OWN, 0, 0, "R4");
        ev(EV_START, 0, 0, 0, "R4");
        ev(EV_ADDR, 7'h55, 0, 0, "R4");
        ev(EV_BYTE, 0, 0, 8'h08, "R4");

        // Constrained random traffic
        for (int i = 0; i < 1500; i++) begin
            int unsigned op = $urandom % 10;
            if (op < 2) ev(EV_START, 0, 0, 0, "R11");
            else if (op == 2) ev(EV_STOP, 0, 0, 0, "R11");
            else if (op < 5) begin
                int unsigned s = $urandom % 7;
                logic [6:0] a;
                case (s)
                    0, 1, 2: a = OWN;
                    3: a = 7'b0001100;
                    4: a = 7'b1101110;
                    5: a = 7'b1111100;
                    default: a = 7'($urandom);
                endcase
                ev(EV_ADDR, a, 1'($urandom), 0, "R3");
            end else begin
                logic [7:0] b;
                if (m_st == B_CMD && ($urandom % 4) != 0) begin
                    int unsigned g = $urandom % 8;
                    if (g < 5) b = 8'(g * 8 + ($urandom % 5));
                    else b = 8'(8'h28 + ($urandom % 3));
                    b[7] = 1'($urandom);
                end else b = 8'($urandom);
                ev(EV_BYTE, 0, 0, b, "R9");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule